// File: doc/BRIEF.md
# Endian-Configurable Load/Store Data Aligner

This block sits between a 64-bit register datapath and a 64-bit data memory port in which each byte has its own address. A store request carries a byte address, a two-bit access size, the store value in its low bytes and an endianness select. From these the block builds per-lane write strobes and a write word whose lanes are already in their memory positions.

For a load, the block takes the 64-bit word that memory returns for the same request. It pulls out the addressed bytes, right-justifies them and fills the upper bits. The fill is either zeros or copies of the chunk's top bit.

A request whose address is not a multiple of its size raises a flag. Such a request produces no strobes and no load data. A parameter places one register stage on all outputs, which suits tight timing paths. The path may also be left purely combinational.

Top module: `lsa_data_aligner`

## Requirements
- R1: The size code is 00 = 1 byte, 01 = 2 bytes, 10 = 4 bytes, 11 = 8 bytes. `misalign` is 1 exactly when the byte address modulo the size in bytes is non-zero.
- R2: With `big_end` = 0, byte k of the value (k = 0 least significant) at address offset o = addr[2:0] maps to memory lane o+k. Lane n is bits 8n+7..8n. Write-data lanes that are not enabled are zero.
- R3: With `big_end` = 1, the byte at the lowest address holds the value's most significant byte, and address offset o maps to lane 7-o. Byte k of an s-byte value therefore goes to lane 7-(o+s-1-k).
- R4: Load data byte k is taken from the same lane that a store of the same address, size and mode would write byte k to.
- R5: For an aligned access, `wr_be` has exactly s bits set, and they are contiguous lanes.
- R6: For a misaligned access, `wr_be` is all zero, `wr_data` is zero and `ld_data` is zero.
- R7: With `ld_signed` = 0, every bit of `ld_data` above the loaded chunk is zero.
- R8: With `ld_signed` = 1 and a size below 8 bytes, every bit of `ld_data` above the chunk equals the chunk's top bit.
- R9: With `REG_OUT` = 1, outputs reflect the inputs sampled at the previous rising clock edge. While `rst` is high, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Byte address of the access |
| size | input | 2 | Access size code |
| big_end | input | 1 | 1 selects big-endian lane mapping |
| ld_signed | input | 1 | 1 selects sign extension of loads |
| st_data | input | 64 | Store value, right-justified |
| mem_rdata | input | 64 | Word returned by memory for a load |
| wr_be | output | 8 | Per-lane write enables |
| wr_data | output | 64 | Lane-positioned store data |
| ld_data | output | 64 | Extracted and extended load value |
| misalign | output | 1 | Illegal alignment flag |

## Verification
The bench sweeps every size against every address offset in both endian modes and both extension modes. This separates legal offsets from flagged ones and little-endian lane placement from big-endian placement.

Two data patterns are used. One has the top bit of every byte clear and the other has it set, so zero fill and sign fill give different results. Upper address bits are changed between passes to show that only the low three bits pick lanes. A probe taken before a clock edge confirms the one-stage latency.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
    parameter int unsigned DATA_W = 64;
    localparam int unsigned LANES  = DATA_W / 8;
    localparam int unsigned OFF_W  = $clog2(LANES);

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'b00,
        SZ_HALF  = 2'b01,
        SZ_WORD  = 2'b10,
        SZ_DWORD = 2'b11
    } acc_size_e;

    typedef struct packed {
        logic [LANES-1:0]  lane_en;
        logic [DATA_W-1:0] data;
    } st_beat_t;

    // number of bytes moved by an access
    function automatic logic [OFF_W:0] size_bytes(input acc_size_e s);
        return (OFF_W+1)'(1) << s;
    endfunction

    // s low lanes set
    function automatic logic [LANES-1:0] size_mask(input acc_size_e s);
        logic [LANES:0] t;
        t = ((LANES+1)'(1) << size_bytes(s)) - (LANES+1)'(1);
        return t[LANES-1:0];
    endfunction

    // lowest lane touched by an access
    function automatic logic [OFF_W:0] lane_base(input logic [OFF_W-1:0] off,
                                                 input acc_size_e s,
                                                 input logic big);
        logic [OFF_W:0] o;
        o = {1'b0, off};
        if (big) return (OFF_W+1)'(LANES) - o - size_bytes(s);
        else     return o;
    endfunction
endpackage

// File: rtl/lsa_align_check.sv
module lsa_align_check
    import lsa_pkg::*;
(
    input  logic [OFF_W-1:0] off,
    input  acc_size_e        size,
    output logic             misalign
);
    logic [OFF_W:0] low_mask;

    always_comb begin
        low_mask = size_bytes(size) - (OFF_W+1)'(1);
        misalign = |({1'b0, off} & low_mask);
    end
endmodule

// File: rtl/lsa_store_lane.sv
module lsa_store_lane
    import lsa_pkg::*;
(
    input  logic [DATA_W-1:0] st_data,
    input  acc_size_e         size,
    input  logic [OFF_W:0]    base,
    input  logic              misalign,
    output st_beat_t          beat
);
    localparam int unsigned SH_W = OFF_W + 4;

    logic [LANES-1:0]  keep;
    logic [DATA_W-1:0] trimmed;
    logic [SH_W-1:0]   bit_sh;

    assign keep = size_mask(size);

    for (genvar i = 0; i < LANES; i++) begin : g_trim
        assign trimmed[8*i +: 8] = keep[i] ? st_data[8*i +: 8] : 8'h00;
    end

    always_comb begin
        bit_sh = {base, 3'b000};
        if (misalign) begin
            beat.lane_en = '0;
            beat.data    = '0;
        end else begin
            beat.lane_en = keep << base;
            beat.data    = trimmed << bit_sh;
        end
    end
endmodule

// File: rtl/lsa_load_extract.sv
module lsa_load_extract
    import lsa_pkg::*;
(
    input  logic [DATA_W-1:0] mem_word,
    input  acc_size_e         size,
    input  logic [OFF_W:0]    base,
    input  logic              sign_ext,
    input  logic              misalign,
    output logic [DATA_W-1:0] value
);
    localparam int unsigned SH_W = OFF_W + 4;

    logic [LANES-1:0]  keep;
    logic [DATA_W-1:0] shifted;
    logic [DATA_W-1:0] filled;
    logic [SH_W-1:0]   bit_sh;
    logic              top_bit;
    logic [7:0]        fill_byte;

    always_comb begin
        bit_sh  = {base, 3'b000};
        shifted = mem_word >> bit_sh;
        keep    = size_mask(size);
        unique case (size)
            SZ_BYTE:  top_bit = shifted[7];
            SZ_HALF:  top_bit = shifted[15];
            SZ_WORD:  top_bit = shifted[31];
            default:  top_bit = shifted[DATA_W-1];
        endcase
        fill_byte = {8{sign_ext & top_bit}};
    end

    for (genvar i = 0; i < LANES; i++) begin : g_fill
        assign filled[8*i +: 8] = keep[i] ? shifted[8*i +: 8] : fill_byte;
    end

    assign value = misalign ? '0 : filled;
endmodule

// File: rtl/lsa_data_aligner.sv
module lsa_data_aligner
    import lsa_pkg::*;
#(
    parameter int unsigned ADDR_W  = 16,
    parameter bit          REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic              big_end,
    input  logic              ld_signed,
    input  logic [63:0]       st_data,
    input  logic [63:0]       mem_rdata,
    output logic [7:0]        wr_be,
    output logic [63:0]       wr_data,
    output logic [63:0]       ld_data,
    output logic              misalign
);
    acc_size_e         sz;
    logic [OFF_W-1:0]  off;
    logic [OFF_W:0]    base;
    logic              mis_c;
    st_beat_t          beat_c;
    logic [DATA_W-1:0] ld_c;

    assign sz   = acc_size_e'(size);
    assign off  = addr[OFF_W-1:0];
    assign base = lane_base(off, sz, big_end);

    lsa_align_check i_check (
        .off      (off),
        .size     (sz),
        .misalign (mis_c)
    );

    lsa_store_lane i_store (
        .st_data  (st_data),
        .size     (sz),
        .base     (base),
        .misalign (mis_c),
        .beat     (beat_c)
    );

    lsa_load_extract i_load (
        .mem_word (mem_rdata),
        .size     (sz),
        .base     (base),
        .sign_ext (ld_signed),
        .misalign (mis_c),
        .value    (ld_c)
    );

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                wr_be    <= '0;
                wr_data  <= '0;
                ld_data  <= '0;
                misalign <= 1'b0;
            end else begin
                wr_be    <= beat_c.lane_en;
                wr_data  <= beat_c.data;
                ld_data  <= ld_c;
                misalign <= mis_c;
            end
        end
    end else begin : g_comb
        assign wr_be    = beat_c.lane_en;
        assign wr_data  = beat_c.data;
        assign ld_data  = ld_c;
        assign misalign = mis_c;
    end

    // flagged requests leave memory and the register file untouched
    p_misalign_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        mis_c |-> (beat_c.lane_en == '0 && ld_c == '0));

    // legal requests strobe exactly size lanes
    p_lane_count_r5: assert property (@(posedge clk) disable iff (rst)
        !mis_c |-> ($countones(beat_c.lane_en) == (1 << size)));

    // unsigned sub-word loads are zero above the chunk
    p_zero_fill_r7: assert property (@(posedge clk) disable iff (rst)
        (!mis_c && !ld_signed && sz != SZ_DWORD) |-> ((ld_c >> (8 << size)) == '0));

    // signed byte loads copy bit 7 upward
    p_sign_fill_r8: assert property (@(posedge clk) disable iff (rst)
        (!mis_c && ld_signed && sz == SZ_BYTE) |-> (ld_c[63:8] == {56{ld_c[7]}}));
endmodule

// File: tb/test_lsa_data_aligner.sv
`timescale 1ns/1ps
module test_lsa_data_aligner;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] addr = '0;
    logic [1:0]  size = '0;
    logic        big_end = 1'b0;
    logic        ld_signed = 1'b0;
    logic [63:0] st_data = '0;
    logic [63:0] mem_rdata = '0;
    logic [7:0]  wr_be;
    logic [63:0] wr_data;
    logic [63:0] ld_data;
    logic        misalign;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    lsa_data_aligner i_lsa_data_aligner (
        .clk(clk), .rst(rst), .addr(addr), .size(size), .big_end(big_end),
        .ld_signed(ld_signed), .st_data(st_data), .mem_rdata(mem_rdata),
        .wr_be(wr_be), .wr_data(wr_data), .ld_data(ld_data), .misalign(misalign)
    );

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // behavioural reference, byte by byte
    task automatic apply(input logic [15:0] a, input int szc, input logic be_mode,
                         input logic sgn, input logic [63:0] sd, input logic [63:0] lw);
        int nb = 1 << szc;
        int off = int'(a[2:0]);
        logic emis;
        logic [7:0] ebe = '0;
        logic [63:0] ewr = '0;
        logic [63:0] eld = '0;
        emis = (off % nb) != 0;
        if (!emis) begin
            for (int k = 0; k < nb; k++) begin
                int lane = be_mode ? 7 - (off + nb - 1 - k) : off + k;
                ebe[lane] = 1'b1;
                ewr[lane*8 +: 8] = sd[k*8 +: 8];
                eld[k*8 +: 8] = lw[lane*8 +: 8];
            end
            if (sgn && nb < 8 && eld[nb*8-1])
                for (int b = nb*8; b < 64; b++) eld[b] = 1'b1;
        end
        addr = a; size = 2'(szc); big_end = be_mode; ld_signed = sgn;
        st_data = sd; mem_rdata = lw;
        @(negedge clk);
        chk("R1", {63'd0, misalign}, {63'd0, emis});
        chk(emis ? "R6" : "R5", {56'd0, wr_be}, {56'd0, ebe});
        chk(emis ? "R6" : (be_mode ? "R3" : "R2"), wr_data, ewr);
        chk(emis ? "R6" : (sgn ? "R8" : (nb < 8 ? "R7" : "R4")), ld_data, eld);
    endtask

    initial begin
        #3_000_000;
        n_bad++; n_chk++;
        $display("FAIL watchdog: got hang expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset holds outputs at zero
        addr = 16'h0001; size = 2'b00; st_data = 64'hFF;
        @(negedge clk);
        chk("R9", {55'd0, misalign, wr_be}, 64'd0);
        chk("R9", ld_data | wr_data, 64'd0);
        rst = 1'b0;
        // R9: output stays put until the next rising edge
        addr = 16'h0003; size = 2'b00; big_end = 1'b0; st_data = 64'hAB;
        #5;
        chk("R9", {56'd0, wr_be}, 64'd0);
        @(negedge clk);
        chk("R2", {56'd0, wr_be}, 64'h08);
        big_end = 1'b1;
        @(negedge clk);
        chk("R3", {56'd0, wr_be}, 64'h10);
        // full sweep
        for (int pass = 0; pass < 2; pass++) begin
            logic [63:0] pat = pass == 0 ? 64'h7766554433221100 : 64'hF0E1D2C3B4A59687;
            logic [15:0] hi = pass == 0 ? 16'h0000 : 16'hA5F0;
            for (int s = 0; s < 4; s++)
                for (int o = 0; o < 8; o++)
                    for (int m = 0; m < 4; m++)
                        apply(hi | 16'(o), s, m[0], m[1], pat ^ 64'h0102030405060708, pat);
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule